// File: doc/BRIEF.md
# External Bus Strobe Generator

This block produces the timing strobes for the multiplexed external memory bus of an 8-bit microcontroller core. It runs at the oscillator rate. A free-running counter splits each machine cycle into twelve phases. From that counter the block emits two outputs: the address-latch pulse (`ale`) and the active-low program-read strobe (`psen_n`). It also tells the port 2 pad logic which source to drive: the special-function-register contents, the high byte of the code address, or the high byte of the data pointer.

The core marks the start of each external data access with a one-cycle pulse at phase 0, together with that access's address width. The block then drops program-read strobes and one latch pulse around the data transfer. It also handles a software bit that stops the latch pulse. While that bit is in force, the pin is only weakly held high. The bit is ignored when code runs from external memory, during a table read from code space, around an external data access, and in the two low-power modes.

Top module: `bus_strobe_gen`

## Requirements
- R1: After reset the phase counter is 0. It advances by one each clock and returns to 0 after the last phase (12 phases by default). In normal operation `ale` is 1 in phases 0, 1, 6 and 7 and 0 in every other phase.
- R2: With `ext_code`=1, `psen_n` is 0 in phases 2, 3, 8 and 9 and 1 in every other phase. With `ext_code`=0, `psen_n` stays 1 whenever neither low-power mode is active.
- R3: `xdata_start` is taken when the counter is at phase 0. Program-read strobes are then suppressed (`psen_n`=1) in phases 6–11 of that machine cycle and in phases 0–5 of the next one.
- R4: An accepted data access suppresses only the `ale` pulse in phases 0–1 of the next machine cycle. The pulse in phases 6–7 of the access cycle still occurs.
- R5: `p2_sel` uses the encoding 0 = port register, 1 = code address high byte, 2 = data pointer high byte. Inside the R3 window it is 2 if the width captured with the access (`xdata_wide`=1) is 16 bits, and 0 otherwise. Outside the window it is 1 when `ext_code`=1 and 0 when `ext_code`=0.
- R6: The `ale_off` bit is registered, and the register is cleared while `rst` is high. While the registered bit is set and nothing suspends it, `ale` is held at 1 and `ale_pullup` is 1.
- R7: The registered `ale_off` bit has no effect, and `ale_pullup` is 0, while any of the following holds: `ext_code`, `code_read`, `idle` or `pdown` is 1, or the cycle lies anywhere from phase 1 of an accepted access's machine cycle through phase 5 of the next machine cycle.
- R8: With `idle`=1 and `pdown`=0, `ale`=1 and `psen_n`=1.
- R9: With `pdown`=1, `ale`=0, `psen_n`=0 and `p2_sel`=0, whatever the state of `idle`.
- R10: An `xdata_start` pulse in any phase other than 0 is ignored: strobes and `p2_sel` are unchanged by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_code | input | 1 | Code is fetched from external program memory |
| xdata_start | input | 1 | One-cycle marker of an external data access, valid at phase 0 |
| xdata_wide | input | 1 | Address width of the access: 1 = 16-bit via data pointer, 0 = 8-bit |
| code_read | input | 1 | A table read from code space is in progress |
| idle | input | 1 | Idle mode |
| pdown | input | 1 | Power-down mode |
| ale_off | input | 1 | Software request to stop the latch pulse |
| ale | output | 1 | Address-latch strobe |
| psen_n | output | 1 | Program-read strobe, active low |
| ale_pullup | output | 1 | Release the latch-pin driver and keep only the weak pullup |
| p2_sel | output | 2 | Port 2 source select (encoding in R5) |

## Verification
The bench uses the default of twelve phases per machine cycle. That puts the window boundaries at phases 5/6 and 11/0, so every suppression edge is reached within two machine cycles. Random accesses start back to back, which lets a new access open while the previous one's second half is still running. Random starts at nonzero phases, mode changes in mid-cycle, and resets with the disable bit set all drive the R7 suspension paths and the R10 filtering. Directed cases pin down the single dropped latch pulse and the register-versus-pointer choice on port 2.

// File: rtl/bus_strobe_pkg.sv
package bus_strobe_pkg;

    typedef enum logic [1:0] {
        P2_PORT_REG = 2'd0,
        P2_CODE_HI  = 2'd1,
        P2_DATA_HI  = 2'd2
    } p2_src_e;

    // Data-access window state: first half covers the access cycle,
    // second half covers the first part of the following cycle.
    typedef struct packed {
        logic first_on;
        logic first_wide;
        logic second_on;
        logic second_wide;
    } xwin_t;

    function automatic logic pair_hit(input int ph, input int base);
        return (ph == base) || (ph == base + 1);
    endfunction

endpackage

// File: rtl/phase_counter.sv
module phase_counter #(
    parameter int PHASES = 12,
    localparam int PW = $clog2(PHASES)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [PW-1:0] phase
);
    localparam logic [PW-1:0] LAST = PW'(PHASES - 1);

    always_ff @(posedge clk) begin
        if (rst)                phase <= '0;
        else if (phase == LAST) phase <= '0;
        else                    phase <= phase + 1'b1;
    end

    // R1: wrap and step
    a_r1_wrap: assert property (@(posedge clk) disable iff (rst)
        phase == LAST |=> phase == '0);
    a_r1_step: assert property (@(posedge clk) disable iff (rst)
        (phase != LAST) && !$past(rst) |=> phase == $past(phase) + 1'b1);
endmodule

// File: rtl/xdata_window.sv
module xdata_window
    import bus_strobe_pkg::*;
#(
    parameter int PHASES = 12,
    localparam int PW = $clog2(PHASES),
    localparam int HALF = PHASES / 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] phase,
    input  logic          start,
    input  logic          wide,
    output xwin_t         win
);
    localparam logic [PW-1:0] LAST     = PW'(PHASES - 1);
    localparam logic [PW-1:0] MID_LAST = PW'(HALF - 1);

    logic take;
    assign take = start && (phase == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            win <= '0;
        end else begin
            if (take) begin
                win.first_on   <= 1'b1;
                win.first_wide <= wide;
            end else if (phase == LAST) begin
                win.first_on   <= 1'b0;
            end
            if (phase == LAST && win.first_on) begin
                win.second_on   <= 1'b1;
                win.second_wide <= win.first_wide;
            end else if (phase == MID_LAST) begin
                win.second_on   <= 1'b0;
            end
        end
    end

    // R3: window opens right after phase 0
    a_r3_open_phase: assert property (@(posedge clk) disable iff (rst)
        $rose(win.first_on) |-> phase == PW'(1));
    // R4: second half begins at phase 0 and closes after the half cycle
    a_r4_second_start: assert property (@(posedge clk) disable iff (rst)
        $rose(win.second_on) |-> phase == '0);
    a_r4_second_end: assert property (@(posedge clk) disable iff (rst)
        win.second_on && phase == MID_LAST |=> !win.second_on);
    // R10: nothing opens from a start outside phase 0
    a_r10_stray: assert property (@(posedge clk) disable iff (rst)
        start && phase != '0 && !win.first_on |=> !win.first_on);
endmodule

// File: rtl/ale_off_ctl.sv
module ale_off_ctl (
    input  logic clk,
    input  logic rst,
    input  logic off_req,
    input  logic suspend,
    output logic off_eff
);
    logic off_q;

    always_ff @(posedge clk) begin
        if (rst) off_q <= 1'b0;
        else     off_q <= off_req;
    end

    assign off_eff = off_q && !suspend;

    // R6: reset leaves the disable inactive on the first cycle after it
    a_r6_reset_clears: assert property (@(posedge clk)
        rst |=> !off_eff);
endmodule

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen
    import bus_strobe_pkg::*;
#(
    parameter int PHASES = 12,
    localparam int PW = $clog2(PHASES),
    localparam int HALF = PHASES / 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ext_code,
    input  logic       xdata_start,
    input  logic       xdata_wide,
    input  logic       code_read,
    input  logic       idle,
    input  logic       pdown,
    input  logic       ale_off,
    output logic       ale,
    output logic       psen_n,
    output logic       ale_pullup,
    output logic [1:0] p2_sel
);
    logic [PW-1:0] phase;
    xwin_t         win;
    logic          off_eff;
    logic          suspend;
    logic          in_xfer;
    logic          xfer_wide;
    logic          ale_slot;
    logic          psen_slot;
    int            ph;

    phase_counter #(.PHASES(PHASES)) u_phase (
        .clk   (clk),
        .rst   (rst),
        .phase (phase)
    );

    xdata_window #(.PHASES(PHASES)) u_win (
        .clk   (clk),
        .rst   (rst),
        .phase (phase),
        .start (xdata_start),
        .wide  (xdata_wide),
        .win   (win)
    );

    assign suspend = ext_code || code_read || idle || pdown
                     || win.first_on || win.second_on;

    ale_off_ctl u_off (
        .clk     (clk),
        .rst     (rst),
        .off_req (ale_off),
        .suspend (suspend),
        .off_eff (off_eff)
    );

    always_comb begin
        ph        = int'(phase);
        ale_slot  = pair_hit(ph, 0) || pair_hit(ph, HALF);
        psen_slot = pair_hit(ph, 2) || pair_hit(ph, HALF + 2);
        in_xfer   = (win.first_on && ph >= HALF) || win.second_on;
        xfer_wide = win.second_on ? win.second_wide : win.first_wide;
    end

    always_comb begin
        ale_pullup = off_eff;
        if (pdown) begin
            ale    = 1'b0;
            psen_n = 1'b0;
            p2_sel = P2_PORT_REG;
        end else begin
            if (idle)                ale = 1'b1;
            else if (off_eff)        ale = 1'b1;
            else if (win.second_on)  ale = 1'b0;
            else                     ale = ale_slot;

            if (idle || !ext_code || in_xfer) psen_n = 1'b1;
            else                              psen_n = !psen_slot;

            if (in_xfer)       p2_sel = xfer_wide ? P2_DATA_HI : P2_PORT_REG;
            else if (ext_code) p2_sel = P2_CODE_HI;
            else               p2_sel = P2_PORT_REG;
        end
    end

    // R9: power-down holds both strobes low
    a_r9_pdown_low: assert property (@(posedge clk) disable iff (rst)
        pdown |-> !ale && !psen_n);
    // R8: idle holds both strobes high
    a_r8_idle_high: assert property (@(posedge clk) disable iff (rst)
        idle && !pdown |-> ale && psen_n);
    // R7: weak pullup only when no suspension applies
    a_r7_pullup_free: assert property (@(posedge clk) disable iff (rst)
        ale_pullup |-> !ext_code && !code_read && !idle && !pdown
                       && !win.first_on && !win.second_on);
    // R2: no program strobe while running internally
    a_r2_internal_quiet: assert property (@(posedge clk) disable iff (rst)
        !ext_code && !pdown |-> psen_n);
    // R5: data pointer byte only inside a transfer window
    a_r5_dptr_in_window: assert property (@(posedge clk) disable iff (rst)
        p2_sel == P2_DATA_HI |-> win.first_on || win.second_on);
endmodule

// File: tb/tb_bus_strobe_gen.sv
`timescale 1ns/1ps
module tb_bus_strobe_gen;
    localparam int NPH  = 12;
    localparam int HLF  = NPH / 2;

    logic clk = 1'b0;
    logic rst, ext_code, xdata_start, xdata_wide, code_read, idle, pdown, ale_off;
    logic ale, psen_n, ale_pullup;
    logic [1:0] p2_sel;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    string force_tag = "";

    // bench model state
    int m_ph;
    bit m_fa, m_fw, m_sa, m_sw, m_oq;

    always #10 clk = ~clk;

    bus_strobe_gen dut (
        .clk(clk), .rst(rst), .ext_code(ext_code), .xdata_start(xdata_start),
        .xdata_wide(xdata_wide), .code_read(code_read), .idle(idle),
        .pdown(pdown), .ale_off(ale_off), .ale(ale), .psen_n(psen_n),
        .ale_pullup(ale_pullup), .p2_sel(p2_sel)
    );

    function automatic bit pr(int p, int b);
        return (p == b) || (p == b + 1);
    endfunction

    function automatic bit m_supp();
        return m_oq && !ext_code && !code_read && !idle && !pdown && !m_fa && !m_sa;
    endfunction

    function automatic bit m_xfer();
        return (m_fa && m_ph >= HLF) || m_sa;
    endfunction

    function automatic bit exp_ale();
        if (pdown) return 1'b0;
        if (idle || m_supp()) return 1'b1;
        if (m_sa) return 1'b0;
        return pr(m_ph, 0) || pr(m_ph, HLF);
    endfunction

    function automatic bit exp_psen();
        if (pdown) return 1'b0;
        if (idle || !ext_code || m_xfer()) return 1'b1;
        return !(pr(m_ph, 2) || pr(m_ph, HLF + 2));
    endfunction

    function automatic logic [1:0] exp_sel();
        if (pdown) return 2'd0;
        if (m_fa && m_ph >= HLF) return m_fw ? 2'd2 : 2'd0;
        if (m_sa) return m_sw ? 2'd2 : 2'd0;
        return ext_code ? 2'd1 : 2'd0;
    endfunction

    task automatic check(input logic [1:0] act, input logic [1:0] exp, input string tag, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s phase=%0d actual=%0d expected=%0d",
                     (force_tag != "") ? force_tag : tag, what, m_ph, act, exp);
        end
    endtask

    task automatic check_all();
        string ta, tp;
        if (pdown) ta = "R9"; else if (idle) ta = "R8"; else if (m_supp()) ta = "R6";
        else if (m_sa) ta = "R4"; else ta = "R1";
        if (pdown) tp = "R9"; else if (idle) tp = "R8"; else if (m_xfer()) tp = "R3"; else tp = "R2";
        check({1'b0, ale},    {1'b0, exp_ale()},  ta, "ale");
        check({1'b0, psen_n}, {1'b0, exp_psen()}, tp, "psen_n");
        check({1'b0, ale_pullup}, {1'b0, m_supp()}, m_oq ? "R7" : "R6", "ale_pullup");
        check(p2_sel, exp_sel(), pdown ? "R9" : "R5", "p2_sel");
    endtask

    task automatic model_step();
        bit take;
        if (rst) begin
            m_ph = 0; m_fa = 0; m_fw = 0; m_sa = 0; m_sw = 0; m_oq = 0;
        end else begin
            take = xdata_start && (m_ph == 0);
            if (m_ph == HLF - 1) m_sa = 0;
            if (m_ph == NPH - 1 && m_fa) begin m_sa = 1; m_sw = m_fw; end
            if (take) begin m_fa = 1; m_fw = xdata_wide; end
            else if (m_ph == NPH - 1) m_fa = 0;
            m_oq = ale_off;
            m_ph = (m_ph == NPH - 1) ? 0 : m_ph + 1;
        end
    endtask

    // one clock: check at negedge, advance model, apply next inputs
    task automatic cycle();
        @(posedge clk);
        @(negedge clk);
        check_all();
    endtask

    task automatic tick();
        model_step();
        cycle();
    endtask

    task automatic clear_in();
        ext_code = 0; xdata_start = 0; xdata_wide = 0; code_read = 0;
        idle = 0; pdown = 0; ale_off = 0;
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(20 * 60000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        void'($urandom(32'd4711));
        clear_in();
        rst = 1;
        m_ph = 0; m_fa = 0; m_fw = 0; m_sa = 0; m_sw = 0; m_oq = 0;
        @(negedge clk);
        tick();
        // R1: reset state, phase 0 has ale high
        force_tag = "R1";
        check({1'b0, ale}, 2'd1, "R1", "reset ale");
        force_tag = "";
        rst = 0;

        // R1/R2: plain internal then external running
        repeat (24) tick();
        ext_code = 1;
        repeat (24) tick();

        // R3/R4/R5: one directed 16-bit access, then an 8-bit one
        while (m_ph != 0) tick();
        xdata_start = 1; xdata_wide = 1;
        tick();
        xdata_start = 0; xdata_wide = 0;
        repeat (NPH - 1) tick();
        xdata_start = 1;
        tick();
        xdata_start = 0;
        repeat (2 * NPH) tick();

        // R10: stray start at phase 3 must change nothing
        force_tag = "R10";
        while (m_ph != 3) tick();
        xdata_start = 1; xdata_wide = 1;
        tick();
        xdata_start = 0; xdata_wide = 0;
        repeat (2 * NPH) tick();
        force_tag = "";

        // R6/R7: disable bit with internal code, then reset clears it
        ext_code = 0; ale_off = 1;
        repeat (NPH) tick();
        rst = 1;
        tick();
        force_tag = "R6";
        check({1'b0, ale_pullup}, 2'd0, "R6", "pullup after reset");
        force_tag = "";
        rst = 0;
        repeat (NPH) tick();
        code_read = 1;
        repeat (4) tick();
        code_read = 0;

        // random phase
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 3) ext_code = ~ext_code;
            r = $urandom_range(0, 99);
            idle  = (r < 6);
            pdown = (r >= 6 && r < 10);
            code_read = ($urandom_range(0, 99) < 10);
            if ($urandom_range(0, 99) < 5) ale_off = ~ale_off;
            xdata_start = (m_ph == 0) ? ($urandom_range(0, 99) < 45)
                                      : ($urandom_range(0, 99) < 8);
            xdata_wide = $urandom_range(0, 1);
            rst = ($urandom_range(0, 999) < 3);
            tick();
        end
        clear_in();
        rst = 0;
        tick();

        done = 1;
        summary();
    end
endmodule